// File: doc/BRIEF.md
# Mode-Selectable 16-bit Timer/Event Counter

This block is a 16-bit up-counter that advances on a count-enable tick. A two-bit mode field picks one of four behaviours. The counter can be held at zero, left free-running, cleared and restarted by a qualifying edge on an external trigger input, or cleared and restarted when the count reaches compare register 0. A second compare register adds a further match point. A timer output pin toggles on a match with either compare register. As an option, the output also toggles on each qualifying trigger edge.

An overflow flag records every wrap of the count from its maximum to zero. Software reads and writes the flag through the control register. The trigger input passes through a two-stage synchroniser, and a two-bit edge-select input picks which of its transitions count as valid. Software uses a small register bus to program the control word and both compare values, and to read them back along with the live count.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control register reads 0x0000, the count reads 0, and `tmr_out` and `ovf_flag` are low.
- R2: While the mode field is 00, each clock forces the count to 0 and clears the overflow flag, and `tmr_out` holds its level whatever the tick and trigger do.
- R3: In mode 01 the count rises by exactly 1 on every clock with `tick` high, wrapping from 0xFFFF to 0, and holds on every clock with `tick` low. A trigger edge does not clear it.
- R4: In mode 10 a valid trigger edge clears the count. The count reads 0 after the third rising clock edge that follows the change on `trig_in`, and this happens whether or not `tick` is high.
- R5: In mode 11, a tick while the count equals compare register 0 loads 0 in place of the increment. With `tick` always high, the count therefore runs 0 through C and repeats with period C+1.
- R6: In any running mode, a tick while the count equals compare register 0 or compare register 1 inverts `tmr_out` once. With the output-condition bit (control bit 2) at 0, trigger edges leave `tmr_out` unchanged.
- R7: With control bit 2 at 1 in a running mode, a valid trigger edge also inverts `tmr_out`, with the same three-edge latency as R4.
- R8: In every running mode, a tick that moves the count from 0xFFFF to 0 sets `ovf_flag`.
- R9: The overflow flag is control bit 3. A control write with bit 3 = 1 sets it and one with bit 3 = 0 clears it. A wrap in the same clock as a write of 0 leaves the flag set.
- R10: The edge-select encoding is 00 = no edge valid, 01 = rising, 10 = falling, 11 = both. A transition that the setting does not select neither clears the count nor toggles the output.
- R11: The bus addresses are 0 = control (mode in bits 1:0, output condition in bit 2, overflow in bit 3), 1 = compare 0, 2 = compare 1, and 3 = read-only live count. A written compare value reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 2 | Write address |
| wdata | input | 16 | Write data |
| raddr | input | 2 | Read address |
| rdata | output | 16 | Read data, combinational from `raddr` |
| tick | input | 1 | Count-enable pulse |
| trig_in | input | 1 | Asynchronous external trigger |
| edge_sel | input | 2 | Valid trigger edge selection |
| tmr_out | output | 1 | Toggling timer output |
| ovf_flag | output | 1 | Overflow flag |

## Verification
A count register that has gone wrong shows up at address 3 on the very next clock. It also shifts every later match, so `tmr_out` flips one or more ticks early or late. A fault in the synchroniser or edge selector appears as a clear or toggle one clock off from the three-edge latency, or as a reaction to a transition that was not selected. Overflow and mode-field faults show on `ovf_flag` within one clock of the wrap, the write or the stop.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

   typedef enum logic [1:0] {
      MODE_STOP  = 2'b00,
      MODE_FREE  = 2'b01,
      MODE_TRIG  = 2'b10,
      MODE_MATCH = 2'b11
   } tmr_mode_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_CMP0  = 2'd1;
   localparam logic [1:0] ADDR_CMP1  = 2'd2;
   localparam logic [1:0] ADDR_COUNT = 2'd3;

   localparam int CTRL_COND_BIT = 2;
   localparam int CTRL_OVF_BIT  = 3;
   localparam int CTRL_BITS     = 4;

endpackage

// File: rtl/evt_timer16_trig.sv
module evt_timer16_trig
   import evt_timer16_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_in,
   input  logic [1:0] edge_sel,
   output logic       trig_edge
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evt_timer16_trig: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;
   logic              rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], trig_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;
   assign fall = ~chain_q[STAGES-1] & last_q;

   always_comb begin
      case (edge_sel_e'(edge_sel))
         EDGE_RISE: trig_edge = rise;
         EDGE_FALL: trig_edge = fall;
         EDGE_BOTH: trig_edge = rise | fall;
         default:   trig_edge = 1'b0;
      endcase
   end

endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core
   import evt_timer16_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int NCMP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_mode_e        mode,
   input  logic             tick,
   input  logic             trig_edge,
   input  logic [WIDTH-1:0] cmp [NCMP],
   output logic [WIDTH-1:0] count,
   output logic             wrap,
   output logic             match
);

   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   logic            run, trig_clr, step, top_clr;
   logic [NCMP-1:0] hit;

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      assign hit[i] = (count == cmp[i]);
   end

   assign run      = (mode != MODE_STOP);
   assign trig_clr = run && (mode == MODE_TRIG) && trig_edge;
   assign step     = run && tick && !trig_clr;
   assign top_clr  = step && (mode == MODE_MATCH) && hit[0];
   assign match    = step && (|hit);
   assign wrap     = step && (count == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (!run || trig_clr) begin
         count <= '0;
      end else if (step) begin
         count <= top_clr ? '0 : count + 1'b1;
      end
   end

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
   import evt_timer16_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [1:0]       raddr,
   output logic [WIDTH-1:0] rdata,
   input  logic             tick,
   input  logic             trig_in,
   input  logic [1:0]       edge_sel,
   output logic             tmr_out,
   output logic             ovf_flag
);

   localparam int NCMP = 2;

   if (WIDTH < CTRL_BITS) begin : g_bad_width
      $error("evt_timer16: WIDTH too small for the control word");
   end

   tmr_mode_e        mode_q;
   logic             cond_q;
   logic             ovf_q;
   logic             out_q;
   logic [WIDTH-1:0] cmp_q [NCMP];
   logic [WIDTH-1:0] count_q;
   logic             trig_edge, wrap, match, run, wr_ctrl, toggle;

   assign run     = (mode_q != MODE_STOP);
   assign wr_ctrl = wr_en && (waddr == ADDR_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_STOP;
         cond_q <= 1'b0;
      end else if (wr_ctrl) begin
         mode_q <= tmr_mode_e'(wdata[1:0]);
         cond_q <= wdata[CTRL_COND_BIT];
      end
   end

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp_reg
      localparam logic [1:0] CH_ADDR = 2'(int'(ADDR_CMP0) + i);
      always_ff @(posedge clk) begin
         if (!rst_n)
            cmp_q[i] <= '0;
         else if (wr_en && (waddr == CH_ADDR))
            cmp_q[i] <= wdata;
      end
   end

   evt_timer16_trig #(.STAGES(SYNC_STAGES)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_in   (trig_in),
      .edge_sel  (edge_sel),
      .trig_edge (trig_edge)
   );

   evt_timer16_core #(.WIDTH(WIDTH), .NCMP(NCMP)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .tick      (tick),
      .trig_edge (trig_edge),
      .cmp       (cmp_q),
      .count     (count_q),
      .wrap      (wrap),
      .match     (match)
   );

   assign toggle = run && (match || (cond_q && trig_edge));

   always_ff @(posedge clk) begin
      if (!rst_n)
         out_q <= 1'b0;
      else
         out_q <= out_q ^ toggle;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         ovf_q <= 1'b0;
      else if (wrap)
         ovf_q <= 1'b1;
      else if (wr_ctrl)
         ovf_q <= wdata[CTRL_OVF_BIT];
   end

   always_comb begin
      rdata = '0;
      case (raddr)
         ADDR_CTRL: begin
            rdata[1:0]           = mode_q;
            rdata[CTRL_COND_BIT] = cond_q;
            rdata[CTRL_OVF_BIT]  = ovf_q;
         end
         ADDR_CMP0: rdata = cmp_q[0];
         ADDR_CMP1: rdata = cmp_q[1];
         default:   rdata = count_q;
      endcase
   end

   assign tmr_out  = out_q;
   assign ovf_flag = ovf_q;

endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             trig_edge,
   input logic [1:0]       mode,
   input logic             cond,
   input logic [WIDTH-1:0] cmp0,
   input logic [WIDTH-1:0] count,
   input logic             tmr_out,
   input logic             ovf_flag
);

   localparam logic [WIDTH-1:0] ALL_ONES = '1;

   p_stop_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |=> (count == '0 && !ovf_flag));

   p_stop_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |=> $stable(tmr_out));

   p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && tick) |=> (count == $past(count) + 1'b1));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && !tick && !(mode == 2'd2 && trig_edge)) |=> $stable(count));

   p_trig_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && trig_edge) |=> (count == '0));

   p_match_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && tick && count == cmp0) |=> (count == '0));

   p_quiet_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && !tick && !(cond && trig_edge)) |=> $stable(tmr_out));

   p_trig_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && cond && trig_edge && !tick) |=> (tmr_out != $past(tmr_out)));

   p_wrap_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && tick && count == ALL_ONES && !(mode == 2'd2 && trig_edge))
      |=> ovf_flag);

endmodule

bind evt_timer16 evt_timer16_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .trig_edge (trig_edge),
   .mode      (mode_q),
   .cond      (cond_q),
   .cmp0      (cmp_q[0]),
   .count     (count_q),
   .tmr_out   (tmr_out),
   .ovf_flag  (ovf_flag)
);

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  waddr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [1:0]  raddr = 2'd3;
   logic [15:0] rdata;
   logic        tick = 1'b0;
   logic        trig_in = 1'b0;
   logic [1:0]  edge_sel = 2'd0;
   logic        tmr_out, ovf_flag;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   evt_timer16 u_evt_timer16 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata), .tick(tick), .trig_in(trig_in),
      .edge_sel(edge_sel), .tmr_out(tmr_out), .ovf_flag(ovf_flag)
   );

   // ---------------- reference model built from the requirements -------------
   function automatic logic edge_ok(logic [1:0] sel, logic cur, logic prev);
      case (sel)
         2'b01:   return cur & ~prev;
         2'b10:   return ~cur & prev;
         2'b11:   return cur ^ prev;
         default: return 1'b0;
      endcase
   endfunction

   logic [15:0] m_cnt, m_c0, m_c1;
   logic [1:0]  m_mode;
   logic        m_cond, m_out, m_ovf;
   logic [2:0]  m_sy;
   logic        m_run, m_edge, m_tclr, m_step, m_wrap, m_hit;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 16'd0; m_c0 <= 16'd0; m_c1 <= 16'd0; m_mode <= 2'd0;
         m_cond <= 1'b0; m_out <= 1'b0; m_ovf <= 1'b0; m_sy <= 3'd0;
      end else begin
         m_run  = (m_mode != 2'd0);
         m_edge = edge_ok(edge_sel, m_sy[1], m_sy[2]);
         m_tclr = m_run && (m_mode == 2'd2) && m_edge;
         m_step = m_run && tick && !m_tclr;
         m_hit  = (m_cnt == m_c0) || (m_cnt == m_c1);
         m_wrap = m_step && (m_cnt == 16'hFFFF);
         if (!m_run || m_tclr)
            m_cnt <= 16'd0;
         else if (m_step)
            m_cnt <= (m_mode == 2'd3 && m_cnt == m_c0) ? 16'd0 : m_cnt + 16'd1;
         if (m_run && ((m_step && m_hit) || (m_cond && m_edge)))
            m_out <= ~m_out;
         if (!m_run)
            m_ovf <= 1'b0;
         else if (m_wrap)
            m_ovf <= 1'b1;
         else if (wr_en && waddr == 2'd0)
            m_ovf <= wdata[3];
         if (wr_en) begin
            case (waddr)
               2'd0: begin m_mode <= wdata[1:0]; m_cond <= wdata[2]; end
               2'd1: m_c0 <= wdata;
               2'd2: m_c1 <= wdata;
               default: ;
            endcase
         end
         m_sy <= {m_sy[1:0], trig_in};
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; waddr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_reg(input string req, input logic [1:0] a, input logic [15:0] exp);
      raddr = a;
      #1;
      chk(req, rdata, exp);
      raddr = 2'd3;
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   logic o;

   initial begin
      void'($urandom(32'd4321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_reg("R1 ctrl", 2'd0, 16'h0000);
      chk_reg("R1 count", 2'd3, 16'h0000);
      chk("R1 out", {15'd0, tmr_out}, 16'd0);
      chk("R1 ovf", {15'd0, ovf_flag}, 16'd0);

      // R2 stopped: ticks do nothing
      tick = 1'b1; cyc(4); tick = 1'b0;
      chk_reg("R2 stopped count", 2'd3, 16'h0000);

      // R11 register access
      wr(2'd2, 16'h8000);
      chk_reg("R11 cmp1", 2'd2, 16'h8000);
      wr(2'd1, 16'h0003);
      chk_reg("R11 cmp0", 2'd1, 16'h0003);
      wr(2'd0, 16'h0005);
      chk_reg("R11 ctrl", 2'd0, 16'h0005);
      wr(2'd0, 16'h0000);

      // R3 free running
      wr(2'd0, 16'h0001);
      tick = 1'b1; cyc(5); tick = 1'b0;
      chk_reg("R3 five ticks", 2'd3, 16'd5);
      cyc(3);
      chk_reg("R3 hold without tick", 2'd3, 16'd5);

      // R5 / R6 match clear on compare 0
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0003);
      o = tmr_out;
      tick = 1'b1; cyc(3);
      chk_reg("R5 reach compare", 2'd3, 16'd3);
      chk("R6 no early toggle", {15'd0, tmr_out}, {15'd0, o});
      cyc(1);
      chk_reg("R5 cleared after compare", 2'd3, 16'd0);
      chk("R6 toggle on cmp0", {15'd0, tmr_out}, {15'd0, ~o});
      cyc(2); tick = 1'b0;
      chk_reg("R5 restart", 2'd3, 16'd2);
      chk("R6 single toggle", {15'd0, tmr_out}, {15'd0, ~o});

      // R6 compare 1 toggles in free-run
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h9000);
      wr(2'd2, 16'h0002);
      wr(2'd0, 16'h0001);
      o = tmr_out;
      tick = 1'b1; cyc(2);
      chk("R6 before cmp1", {15'd0, tmr_out}, {15'd0, o});
      cyc(1); tick = 1'b0;
      chk("R6 toggle on cmp1", {15'd0, tmr_out}, {15'd0, ~o});
      chk_reg("R3 passes cmp1", 2'd3, 16'd3);

      // R4 trigger clear, rising edge
      wr(2'd0, 16'h0000);
      edge_sel = 2'b01;
      wr(2'd0, 16'h0002);
      tick = 1'b1; cyc(6); tick = 1'b0;
      chk_reg("R4 counted", 2'd3, 16'd6);
      o = tmr_out;
      trig_in = 1'b1; cyc(2);
      chk_reg("R4 not yet cleared", 2'd3, 16'd6);
      cyc(1);
      chk_reg("R4 cleared by edge", 2'd3, 16'd0);
      chk("R6 edge ignored cond0", {15'd0, tmr_out}, {15'd0, o});

      // R10 unselected edges ignored
      edge_sel = 2'b00;
      tick = 1'b1; cyc(3); tick = 1'b0;
      trig_in = 1'b0; cyc(4);
      chk_reg("R10 none selected", 2'd3, 16'd3);
      edge_sel = 2'b10;
      trig_in = 1'b1; cyc(4);
      chk_reg("R10 rise ignored on fall select", 2'd3, 16'd3);
      trig_in = 1'b0; cyc(3);
      chk_reg("R4 falling edge clears", 2'd3, 16'd0);

      // R7 output toggles on trigger with condition bit set
      wr(2'd0, 16'h0000);
      edge_sel = 2'b11;
      wr(2'd0, 16'h0005);
      o = tmr_out;
      trig_in = 1'b1; cyc(3);
      chk("R7 toggle on rise", {15'd0, tmr_out}, {15'd0, ~o});
      chk_reg("R3 edge no clear in free-run", 2'd3, 16'd0);
      trig_in = 1'b0; cyc(3);
      chk("R7 toggle on fall", {15'd0, tmr_out}, {15'd0, o});
      wr(2'd0, 16'h0001);
      trig_in = 1'b1; cyc(3);
      chk("R6 no trigger toggle cond0", {15'd0, tmr_out}, {15'd0, o});

      // R9 software write of the flag, R2 stop clears it
      wr(2'd0, 16'h0009);
      chk("R9 write one sets", {15'd0, ovf_flag}, 16'd1);
      wr(2'd0, 16'h0001);
      chk("R9 write zero clears", {15'd0, ovf_flag}, 16'd0);
      wr(2'd0, 16'h0009);
      wr(2'd0, 16'h0008);
      cyc(1);
      chk("R2 stop clears flag", {15'd0, ovf_flag}, 16'd0);

      // R8 overflow, and R9 wrap beats a clearing write
      wr(2'd0, 16'h0001);
      tick = 1'b1; cyc(65535);
      chk_reg("R8 at maximum", 2'd3, 16'hFFFF);
      chk("R8 no flag before wrap", {15'd0, ovf_flag}, 16'd0);
      wr(2'd0, 16'h0001);
      tick = 1'b0;
      chk("R9 wrap beats write zero", {15'd0, ovf_flag}, 16'd1);
      chk_reg("R8 wrapped to zero", 2'd3, 16'h0000);
      wr(2'd0, 16'h0001);
      chk("R9 clear after wrap", {15'd0, ovf_flag}, 16'd0);

      // random phase against the model
      raddr = 2'd3;
      for (int i = 0; i < 3000; i++) begin
         #1;
         chk("R3 random count", rdata, m_cnt);
         chk("R6 random out", {15'd0, tmr_out}, {15'd0, m_out});
         chk("R8 random ovf", {15'd0, ovf_flag}, {15'd0, m_ovf});
         tick = 1'($urandom % 2);
         if ($urandom % 4 == 0) trig_in = ~trig_in;
         if ($urandom % 64 == 0) edge_sel = 2'($urandom % 4);
         wr_en = ($urandom % 12 == 0);
         waddr = 2'($urandom % 3);
         wdata = (waddr == 2'd0) ? 16'($urandom % 16) : 16'($urandom % 24);
         @(negedge clk);
      end
      wr_en = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule